// File: doc/BRIEF.md
# Nested Translation Buffer

This block holds finished guest-physical to system-physical page translations produced by the second-dimension walk of a two-dimensional page walker. Before the walker starts a nested walk for a guest page-table pointer, it offers the guest-physical page number on the lookup port. A hit returns the system-physical page number one cycle later, and the walker skips that nested walk entirely. Because one entry covers a whole guest-physical page, every guest page-table entry on that page is served by the same entry.

When the walker completes a nested walk, it writes the result through the fill port together with its size: a 4KB page or a 2MB page. The store is fully associative and replaces entries in round-robin order. A flush input drops every entry at once. Guest-dimension page-table entries and guest-virtual translations are never kept here.

Top module: `nested_xlat_buf`

## Requirements
- R1: Each lookup is answered exactly one cycle after `lookup_valid` is sampled high, with `resp_valid` high for that one cycle. In every other cycle `resp_valid` is low.
- R2: A 4KB entry hits only when all bits of `lookup_gpn` (guest-physical address bits 47:12) equal its stored page number. On such a hit `resp_spn` is the stored system page number and `resp_large` is 0.
- R3: A 2MB entry hits when `lookup_gpn[35:9]` (address bits 47:21) equals the same bits of its stored page number. On such a hit `resp_large` is 1, and `resp_spn` is the stored system page number with its low 9 bits replaced by `lookup_gpn[8:0]`.
- R4: When a 2MB entry and a 4KB entry both match a lookup, the 2MB result is returned.
- R5: On a miss, `resp_hit` is 0, `resp_large` is 0 and `resp_spn` is 0.
- R6: A fill writes the slot under a replacement pointer. The pointer starts at slot 0 after reset or flush, advances by one on each accepted fill, and wraps after the last slot. With N slots, the (N+1)-th fill evicts the first one.
- R7: A flush invalidates every entry and returns the pointer to slot 0. A fill in the same cycle as a flush is dropped.
- R8: A lookup in the same cycle as a fill or a flush sees the contents from before that clock edge.
- R9: After reset all entries are invalid and `resp_valid`, `resp_hit`, `resp_large` and `resp_spn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_gpn | input | GPA_W-12 (36) | Guest-physical page number to translate |
| resp_valid | output | 1 | Lookup answer valid |
| resp_hit | output | 1 | Translation found |
| resp_large | output | 1 | Answer came from a 2MB entry |
| resp_spn | output | SPA_W-12 (40) | System-physical page number, in 4KB units |
| fill_valid | input | 1 | Write a new translation |
| fill_gpn | input | GPA_W-12 (36) | Guest-physical page number of the new translation |
| fill_spn | input | SPA_W-12 (40) | System-physical page number of the new translation |
| fill_large | input | 1 | New translation is a 2MB page |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with four slots and the default address widths. Four slots let a few fills wrap the replacement pointer, so the eviction of the oldest entry and the restart at slot 0 after a flush can be observed through lookups alone. With the full widths, a mismatch in the top page-number bit and the split between the 2MB tag and the page offset are checked at their real bit positions.

// File: rtl/nested_xlat_buf.sv
module nested_xlat_buf #(
  parameter int GPA_W       = 48,
  parameter int SPA_W       = 52,
  parameter int ENTRIES     = 16,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 21
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lookup_valid,
  input  logic [GPA_W-SMALL_SHIFT-1:0] lookup_gpn,
  output logic                         resp_valid,
  output logic                         resp_hit,
  output logic                         resp_large,
  output logic [SPA_W-SMALL_SHIFT-1:0] resp_spn,
  input  logic                         fill_valid,
  input  logic [GPA_W-SMALL_SHIFT-1:0] fill_gpn,
  input  logic [SPA_W-SMALL_SHIFT-1:0] fill_spn,
  input  logic                         fill_large,
  input  logic                         flush
);

  localparam int GPN_W = GPA_W - SMALL_SHIFT;
  localparam int SPN_W = SPA_W - SMALL_SHIFT;
  localparam int OFF_W = LARGE_SHIFT - SMALL_SHIFT;
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] large_q;
  logic [GPN_W-1:0]   tag_q [ENTRIES];
  logic [SPN_W-1:0]   spn_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;

  logic [ENTRIES-1:0] hit_small;
  logic [ENTRIES-1:0] hit_big;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_small[i] = valid_q[i] && !large_q[i] && (tag_q[i] == lookup_gpn);
    assign hit_big[i]   = valid_q[i] && large_q[i] &&
                          (tag_q[i][GPN_W-1:OFF_W] == lookup_gpn[GPN_W-1:OFF_W]);
  end

  logic             sel_found;
  logic             sel_large;
  logic [PTR_W-1:0] sel_idx;

  always_comb begin
    sel_found = 1'b0;
    sel_large = 1'b0;
    sel_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_small[i]) begin
        sel_found = 1'b1;
        sel_idx   = PTR_W'(i);
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_big[i]) begin
        sel_found = 1'b1;
        sel_large = 1'b1;
        sel_idx   = PTR_W'(i);
      end
    end
  end

  logic [SPN_W-1:0] sel_spn;
  assign sel_spn = !sel_found ? '0 :
                   sel_large  ? {spn_q[sel_idx][SPN_W-1:OFF_W], lookup_gpn[OFF_W-1:0]} :
                                spn_q[sel_idx];

  wire do_fill = fill_valid && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      large_q <= '0;
      rr_q    <= '0;
    end else if (flush) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (do_fill) begin
      valid_q[rr_q] <= 1'b1;
      large_q[rr_q] <= fill_large;
      rr_q          <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[rr_q] <= fill_gpn;
      spn_q[rr_q] <= fill_spn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_large <= 1'b0;
      resp_spn   <= '0;
    end else begin
      resp_valid <= lookup_valid;
      resp_hit   <= lookup_valid && sel_found;
      resp_large <= lookup_valid && sel_large;
      resp_spn   <= lookup_valid ? sel_spn : '0;
    end
  end

  // R1
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> resp_valid);

  // R1
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !resp_valid);

  // R5
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_hit) |-> (!resp_large && resp_spn == '0));

  // R3
  large_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_large |-> (resp_hit && resp_spn[OFF_W-1:0] == $past(lookup_gpn[OFF_W-1:0])));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && lookup_valid) |=> !resp_hit);

  // R6
  fill_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> (valid_q[$past(rr_q)] && tag_q[$past(rr_q)] == $past(fill_gpn)));

endmodule

// File: tb/sim_nested_xlat_buf.sv
`timescale 1ns/1ps
module sim_nested_xlat_buf;
  localparam int GW = 36;
  localparam int SW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookup_valid = 1'b0;
  logic [GW-1:0] lookup_gpn = '0;
  logic resp_valid, resp_hit, resp_large;
  logic [SW-1:0] resp_spn;
  logic fill_valid = 1'b0;
  logic [GW-1:0] fill_gpn = '0;
  logic [SW-1:0] fill_spn = '0;
  logic fill_large = 1'b0;
  logic flush = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  nested_xlat_buf #(.ENTRIES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_gpn(lookup_gpn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_large(resp_large), .resp_spn(resp_spn),
    .fill_valid(fill_valid), .fill_gpn(fill_gpn), .fill_spn(fill_spn),
    .fill_large(fill_large), .flush(flush));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [GW-1:0] g, input bit eh, input bit el,
                      input logic [SW-1:0] es, input string req);
    logic [63:0] act, exp;
    @(negedge clk);
    lookup_valid = 1'b1; lookup_gpn = g;
    @(negedge clk);
    lookup_valid = 1'b0;
    act = {21'd0, resp_valid, resp_hit, resp_large, resp_spn};
    exp = {21'd0, 1'b1, eh, el, es};
    check(act == exp, req, act, exp);
  endtask

  task automatic fill(input logic [GW-1:0] g, input logic [SW-1:0] s, input bit lg);
    @(negedge clk);
    fill_valid = 1'b1; fill_gpn = g; fill_spn = s; fill_large = lg;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] act;
    act = {61'd0, resp_valid, resp_hit, resp_large};
    check(act == 0 && resp_spn == '0, "R9 reset outputs", act, 64'd0);
    look(36'h000123456, 1'b0, 1'b0, '0, "R9 empty after reset");
    @(negedge clk);
    check(resp_valid == 1'b0, "R1 valid drops", {63'd0, resp_valid}, 64'd0);
  endtask

  task automatic t_small();
    fill(36'h000123456, 40'h00ABCDEF01, 1'b0);
    look(36'h000123456, 1'b1, 1'b0, 40'h00ABCDEF01, "R2 small hit");
    look(36'h000123457, 1'b0, 1'b0, '0, "R2 neighbour page miss / R5");
    look(36'h800123456, 1'b0, 1'b0, '0, "R2 top bit mismatch");
  endtask

  task automatic t_large();
    fill(36'h000AAA000, 40'h0055500000, 1'b1);
    look(36'h000AAA000, 1'b1, 1'b1, 40'h0055500000, "R3 large base");
    look(36'h000AAA1FF, 1'b1, 1'b1, 40'h00555001FF, "R3 large last 4KB");
    look(36'h000AAA0C3, 1'b1, 1'b1, 40'h00555000C3, "R3 large inner offset");
    look(36'h000AAA200, 1'b0, 1'b0, '0, "R3 next 2MB miss");
  endtask

  task automatic t_prio();
    fill(36'h000AAA010, 40'h0000077777, 1'b0);
    look(36'h000AAA010, 1'b1, 1'b1, 40'h0055500010, "R4 large preferred");
  endtask

  task automatic t_rr();
    do_flush();
    look(36'h000AAA000, 1'b0, 1'b0, '0, "R7 flush clears large");
    look(36'h000123456, 1'b0, 1'b0, '0, "R7 flush clears small");
    fill(36'h000000001, 40'h0000000011, 1'b0);
    fill(36'h000000002, 40'h0000000022, 1'b0);
    fill(36'h000000003, 40'h0000000033, 1'b0);
    fill(36'h000000004, 40'h0000000044, 1'b0);
    look(36'h000000001, 1'b1, 1'b0, 40'h0000000011, "R6 slot0 kept at capacity");
    look(36'h000000004, 1'b1, 1'b0, 40'h0000000044, "R6 slot3 kept");
    fill(36'h000000005, 40'h0000000055, 1'b0);
    look(36'h000000001, 1'b0, 1'b0, '0, "R6 oldest evicted on wrap");
    look(36'h000000002, 1'b1, 1'b0, 40'h0000000022, "R6 second survives");
    fill(36'h000000006, 40'h0000000066, 1'b0);
    look(36'h000000002, 1'b0, 1'b0, '0, "R6 second evicted next");
    look(36'h000000003, 1'b1, 1'b0, 40'h0000000033, "R6 third survives");
  endtask

  task automatic t_flush_fill();
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_gpn = 36'h000000077; fill_spn = 40'h77; fill_large = 1'b0;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    look(36'h000000077, 1'b0, 1'b0, '0, "R7 fill dropped during flush");
    look(36'h000000005, 1'b0, 1'b0, '0, "R7 all gone");
    fill(36'h000000008, 40'h88, 1'b0);
    fill(36'h000000009, 40'h99, 1'b0);
    fill(36'h00000000A, 40'hAA, 1'b0);
    fill(36'h00000000B, 40'hBB, 1'b0);
    fill(36'h00000000C, 40'hCC, 1'b0);
    look(36'h000000008, 1'b0, 1'b0, '0, "R7 pointer restarted at slot0");
    look(36'h000000009, 1'b1, 1'b0, 40'h99, "R7 slot1 survives");
  endtask

  task automatic t_same_cycle();
    logic [63:0] act;
    @(negedge clk);
    fill_valid = 1'b1; fill_gpn = 36'h000000D00; fill_spn = 40'hD0D0; fill_large = 1'b0;
    lookup_valid = 1'b1; lookup_gpn = 36'h000000D00;
    @(negedge clk);
    fill_valid = 1'b0; lookup_valid = 1'b0;
    act = {62'd0, resp_valid, resp_hit};
    check(act == 64'd2, "R8 lookup with fill sees old", act, 64'd2);
    look(36'h000000D00, 1'b1, 1'b0, 40'hD0D0, "R8 visible next cycle");
    @(negedge clk);
    flush = 1'b1; lookup_valid = 1'b1; lookup_gpn = 36'h000000D00;
    @(negedge clk);
    flush = 1'b0; lookup_valid = 1'b0;
    act = {62'd0, resp_valid, resp_hit};
    check(act == 64'd3, "R8 lookup with flush sees old", act, 64'd3);
    look(36'h000000D00, 1'b0, 1'b0, '0, "R8 flushed afterwards");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_small();
        t_large();
        t_prio();
        t_rr();
        t_flush_fill();
        t_same_cycle();
      end
      begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule